// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block is the coherence engine for one private cache on a small shared-bus multiprocessor. It keeps a direct-mapped array of a few lines. Each line has a tag, a one-word payload and a coherence state: Invalid, Shared or Modified. Processor reads and writes that find the line in a good enough state finish locally. Any other access asks an external arbiter for the bus and issues one of three commands: a read, a read-for-ownership, or a dataless upgrade. The access completes when the transaction finishes.

The block also watches every transaction that other caches place on the bus and applies write-invalidate rules to its own copy. If it owns a line Modified and another cache misses on that line, it intervenes. It supplies the word and tells memory, through a suppress wire, to stay silent. Memory and the arbiter sit outside the block. Victim writeback on replacement is not modelled, so an evicted line is simply overwritten.

The request path is a three-state machine. IDLE looks up the processor address. LOOKUP-HIT completes the access and stays in IDLE. LOOKUP-MISS moves to ARB, which holds the bus request. GRANT-UPGRADE returns from ARB to IDLE. GRANT-FETCH moves from ARB to WAIT. FILL returns from WAIT to IDLE when the bus data arrives, and the access then completes as a hit.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. cpu_ready, bus_req and snp_own are low, and the first read of any address goes to the bus.
- R2: A read miss raises bus_req. In the granted cycle it drives bus_cmd=01 (read) with bus_addr set to the processor address and bus_id set to the cache ID. After bus_dvalid the line is installed Shared, and cpu_ready rises with the delivered word on cpu_rdata.
- R3: A read of a Shared or Modified line, or a write of a Modified line, completes with cpu_ready high in the cycle of the request and never raises bus_req.
- R4: A write to a Shared line issues bus_cmd=11 (upgrade) and does not wait for bus_dvalid. The line becomes Modified, so the next write hits locally.
- R5: A write to an absent line issues bus_cmd=10 (read-for-ownership). After the fill the line is Modified and holds the written word.
- R6: A snooped read of a Shared line changes nothing and does not raise snp_own.
- R7: A snooped upgrade or read-for-ownership of a Shared line invalidates it.
- R8: A snooped read of a Modified line raises snp_own for one cycle, in the cycle after the command, with the line's word on snp_data. The line then becomes Shared.
- R9: A snooped read-for-ownership of a Modified line supplies the word the same way and then invalidates the line.
- R10: Snooped commands carrying the cache's own ID, or a tag that differs from the one stored, leave the line unchanged.
- R11: A pending write whose Shared line is invalidated by a snoop before the grant issues read-for-ownership, not upgrade.
- R12: A processor access whose line index matches an active foreign snoop gets no cpu_ready in that cycle. It completes in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read word, valid with cpu_ready |
| bus_req | output | 1 | Request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_cmd | output | 2 | 00 idle, 01 read, 10 read-for-ownership, 11 upgrade |
| bus_addr | output | AW | Address of the issued command |
| bus_id | output | IDW | Requester ID |
| bus_dvalid | input | 1 | Fill word valid |
| bus_rdata | input | DW | Fill word |
| snp_cmd | input | 2 | Observed bus command |
| snp_addr | input | AW | Observed address |
| snp_id | input | IDW | Observed requester ID |
| snp_own | output | 1 | Intervention: memory must not reply |
| snp_data | output | DW | Word supplied on intervention |

## Verification
The bench drives a line through every state change, then probes its state only through later processor accesses and the command each one issues. Each snooped transition is covered. A controller that dropped Modified to Invalid on a foreign read, or kept Shared after a foreign upgrade, would issue the wrong command or none. The bench stages a race in which the line is invalidated while an upgrade waits for the grant. A design that fixes its command at miss time would send an upgrade for a line it no longer holds. A final case collides a local hit with a foreign snoop to the same index but a different tag. A design without snoop priority would grant the hit in the same cycle, and one that matched on index alone would disturb the line.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        L_INV = 2'b00,
        L_SHR = 2'b01,
        L_MOD = 2'b10
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_RDX  = 2'b10,
        CMD_UPG  = 2'b11
    } bus_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ARB  = 2'b01,
        ST_WAIT = 2'b10
    } fsm_t;

endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
    import msi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TW    = 6,
    parameter int DW    = 32,
    localparam int IW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] a_idx,
    output line_st_t      a_state,
    output logic [TW-1:0] a_tag,
    output logic [DW-1:0] a_data,
    input  logic [IW-1:0] s_idx,
    output line_st_t      s_state,
    output logic [TW-1:0] s_tag,
    output logic [DW-1:0] s_data,
    input  logic          wr_en,
    input  line_st_t      wr_state,
    input  logic [TW-1:0] wr_tag,
    input  logic [DW-1:0] wr_data,
    input  logic          sw_en,
    input  line_st_t      sw_state
);
    line_st_t      st_q  [LINES];
    logic [TW-1:0] tag_q [LINES];
    logic [DW-1:0] dat_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g]  <= L_INV;
                tag_q[g] <= '0;
                dat_q[g] <= '0;
            end else begin
                if (wr_en && a_idx == IW'(g)) begin
                    st_q[g]  <= wr_state;
                    tag_q[g] <= wr_tag;
                    dat_q[g] <= wr_data;
                end
                if (sw_en && s_idx == IW'(g))
                    st_q[g] <= sw_state;
            end
        end

        // R1
        legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] != line_st_t'(2'b11));
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = dat_q[a_idx];
    assign s_state = st_q[s_idx];
    assign s_tag   = tag_q[s_idx];
    assign s_data  = dat_q[s_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
(
    input  bus_cmd_t cmd,
    input  logic     hit,
    input  line_st_t cur,
    output logic     upd,
    output line_st_t nxt,
    output logic     supply
);
    always_comb begin
        upd    = 1'b0;
        nxt    = cur;
        supply = 1'b0;
        if (hit) begin
            unique case (cmd)
                CMD_RD: begin
                    if (cur == L_MOD) begin
                        upd    = 1'b1;
                        nxt    = L_SHR;
                        supply = 1'b1;
                    end
                end
                CMD_RDX: begin
                    upd    = 1'b1;
                    nxt    = L_INV;
                    supply = (cur == L_MOD);
                end
                CMD_UPG: begin
                    upd = 1'b1;
                    nxt = L_INV;
                end
                CMD_IDLE: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int MY_ID = 1,
    parameter int IDW   = 2,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int LINES = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    output logic           cpu_ready,
    output logic [DW-1:0]  cpu_rdata,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic [1:0]     bus_cmd,
    output logic [AW-1:0]  bus_addr,
    output logic [IDW-1:0] bus_id,
    input  logic           bus_dvalid,
    input  logic [DW-1:0]  bus_rdata,
    input  logic [1:0]     snp_cmd,
    input  logic [AW-1:0]  snp_addr,
    input  logic [IDW-1:0] snp_id,
    output logic           snp_own,
    output logic [DW-1:0]  snp_data
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    fsm_t     st_q, st_d;
    line_st_t lk_state, sn_state, wr_state, sn_nxt;
    logic [TW-1:0] lk_tag, sn_tag;
    logic [DW-1:0] lk_data, sn_data, wr_data;
    logic     lk_hit, sn_hit, sn_valid, sn_upd, sn_supply, clash, ok, wr_en;
    bus_cmd_t want_cmd, sn_cmd;

    wire [IW-1:0] c_idx = cpu_addr[IW-1:0];
    wire [TW-1:0] c_tag = cpu_addr[AW-1:IW];
    wire [IW-1:0] s_idx = snp_addr[IW-1:0];

    msi_line_array #(.LINES(LINES), .TW(TW), .DW(DW)) lines_i (
        .clk(clk), .rst_n(rst_n),
        .a_idx(c_idx), .a_state(lk_state), .a_tag(lk_tag), .a_data(lk_data),
        .s_idx(s_idx), .s_state(sn_state), .s_tag(sn_tag), .s_data(sn_data),
        .wr_en(wr_en), .wr_state(wr_state), .wr_tag(c_tag), .wr_data(wr_data),
        .sw_en(sn_upd), .sw_state(sn_nxt)
    );

    assign sn_cmd   = bus_cmd_t'(snp_cmd);
    assign sn_valid = (sn_cmd != CMD_IDLE) && (snp_id != IDW'(MY_ID));
    assign sn_hit   = sn_valid && (sn_state != L_INV) && (sn_tag == snp_addr[AW-1:IW]);

    msi_snoop_unit snoop_i (
        .cmd(sn_cmd), .hit(sn_hit), .cur(sn_state),
        .upd(sn_upd), .nxt(sn_nxt), .supply(sn_supply)
    );

    assign lk_hit = (lk_state != L_INV) && (lk_tag == c_tag);
    assign ok     = lk_hit && (!cpu_we || lk_state == L_MOD);
    assign clash  = sn_valid && (s_idx == c_idx);

    always_comb begin
        if (!cpu_we)                          want_cmd = CMD_RD;
        else if (lk_hit && lk_state == L_SHR) want_cmd = CMD_UPG;
        else                                  want_cmd = CMD_RDX;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d      = st_q;
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = CMD_IDLE;
        wr_en     = 1'b0;
        wr_state  = lk_state;
        wr_data   = lk_data;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_req && !clash) begin
                    if (ok) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            wr_en    = 1'b1;
                            wr_state = L_MOD;
                            wr_data  = cpu_wdata;
                        end
                    end else begin
                        st_d = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd = want_cmd;
                    if (want_cmd == CMD_UPG) begin
                        wr_en    = 1'b1;
                        wr_state = L_MOD;
                        st_d     = ST_IDLE;
                    end else begin
                        st_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (bus_dvalid) begin
                    wr_en    = 1'b1;
                    wr_state = cpu_we ? L_MOD : L_SHR;
                    wr_data  = bus_rdata;
                    st_d     = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign cpu_rdata = lk_data;
    assign bus_addr  = cpu_addr;
    assign bus_id    = IDW'(MY_ID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snp_own  <= 1'b0;
            snp_data <= '0;
        end else begin
            snp_own  <= sn_supply;
            snp_data <= sn_supply ? sn_data : '0;
        end
    end

    // R2
    cmd_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != CMD_IDLE) |-> (bus_req && bus_gnt));

    // R3
    ready_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req);

    // R4
    upg_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_cmd == CMD_UPG) |=> (st_q == ST_IDLE));

    // R5
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && bus_dvalid) |=> (st_q == ST_IDLE));

    // R8
    intervene_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_hit && sn_cmd == CMD_RD && sn_state == L_MOD) |=> snp_own);

    // R6
    shared_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_cmd == CMD_RD && sn_state != L_MOD) |=> !snp_own);

    // R12
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_valid && s_idx == c_idx) |-> !cpu_ready);
endmodule

// File: tb/msi_snoop_ctrl_tb_top.sv
module msi_snoop_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8, DW = 32, IDW = 2, ID = 1;
    localparam logic [1:0] C_IDLE = 2'b00, C_RD = 2'b01, C_RDX = 2'b10, C_UPG = 2'b11;

    logic clk = 0, rst_n = 0;
    logic cpu_req = 0, cpu_we = 0, cpu_ready;
    logic [AW-1:0] cpu_addr = 0, bus_addr, snp_addr = 0;
    logic [DW-1:0] cpu_wdata = 0, cpu_rdata, bus_rdata = 0, snp_data;
    logic bus_req, bus_gnt = 0, bus_dvalid = 0, snp_own;
    logic [1:0] bus_cmd, snp_cmd = 0;
    logic [IDW-1:0] bus_id, snp_id = 0;
    int checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_snoop_ctrl #(.MY_ID(ID), .IDW(IDW), .AW(AW), .DW(DW), .LINES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_id(bus_id), .bus_dvalid(bus_dvalid), .bus_rdata(bus_rdata),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_id(snp_id),
        .snp_own(snp_own), .snp_data(snp_data));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one processor access, acting as arbiter and memory
    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [1:0] exp_cmd, input logic [DW-1:0] fill,
                          input logic [DW-1:0] exp_rd, input string req);
        logic [1:0] seen = C_IDLE;
        bit granted = 0, filled = 0, done = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int i = 0; i < 12 && !done; i++) begin
            #1;
            if (cpu_ready) begin
                done = 1;
                if (!we) chk(cpu_rdata == exp_rd, req, cpu_rdata, exp_rd);
            end else if (bus_req && !granted) begin
                bus_gnt = 1; #1;
                seen = bus_cmd; granted = 1;
                chk(bus_addr == a && bus_id == IDW'(ID), req, {bus_id, bus_addr}, {IDW'(ID), a});
            end else if (granted && !filled && seen != C_UPG) begin
                bus_dvalid = 1; bus_rdata = fill; filled = 1;
            end
            @(negedge clk);
            bus_gnt = 0; bus_dvalid = 0;
        end
        chk(done, req, done, 1);
        chk(seen == exp_cmd, req, seen, exp_cmd);
        cpu_req = 0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [IDW-1:0] id,
                         input bit exp_own, input logic [DW-1:0] exp_d, input string req);
        @(negedge clk);
        snp_cmd = c; snp_addr = a; snp_id = id;
        @(negedge clk);
        snp_cmd = C_IDLE;
        #1;
        chk(snp_own == exp_own, req, snp_own, exp_own);
        if (exp_own) chk(snp_data == exp_d, req, snp_data, exp_d);
        @(negedge clk); #1;
        chk(snp_own == 0, {req, " pulse"}, snp_own, 0);
    endtask

    task automatic t_reset;
        #1;
        chk(!cpu_ready && !bus_req && !snp_own && bus_cmd == C_IDLE, "R1", {cpu_ready, bus_req, snp_own}, 0);
        access(0, 8'h10, 0, C_RD, 32'hAAAA, 32'hAAAA, "R1 R2 read miss");
    endtask

    task automatic t_hits;
        access(0, 8'h10, 0, C_IDLE, 0, 32'hAAAA, "R3 shared read hit");
        snoop(C_RD, 8'h10, 2, 0, 0, "R6 snoop read on S");
        access(0, 8'h10, 0, C_IDLE, 0, 32'hAAAA, "R6 line kept");
    endtask

    task automatic t_upgrade;
        access(1, 8'h10, 32'h1111, C_UPG, 0, 0, "R4 upgrade");
        access(1, 8'h10, 32'h2222, C_IDLE, 0, 0, "R4 write hit on M");
        access(0, 8'h10, 0, C_IDLE, 0, 32'h2222, "R3 read hit on M");
    endtask

    task automatic t_intervene;
        snoop(C_RD, 8'h10, 2, 1, 32'h2222, "R8 supply on read");
        access(1, 8'h10, 32'h3333, C_UPG, 0, 0, "R8 now shared");
        snoop(C_RDX, 8'h10, 2, 1, 32'h3333, "R9 supply on rdx");
        access(0, 8'h10, 0, C_RD, 32'h4444, 32'h4444, "R9 now invalid");
    endtask

    task automatic t_invalidate;
        snoop(C_UPG, 8'h10, 3, 0, 0, "R7 snoop upgrade");
        access(0, 8'h10, 0, C_RD, 32'h5555, 32'h5555, "R7 upg invalidated");
        snoop(C_RDX, 8'h10, 3, 0, 0, "R7 snoop rdx on S");
        access(0, 8'h10, 0, C_RD, 32'h6666, 32'h6666, "R7 rdx invalidated");
    endtask

    task automatic t_write_miss;
        access(1, 8'h21, 32'h7777, C_RDX, 32'h1234, 0, "R5 write miss");
        access(0, 8'h21, 0, C_IDLE, 0, 32'h7777, "R5 merged word");
    endtask

    task automatic t_ignore;
        snoop(C_RDX, 8'h21, IDW'(ID), 0, 0, "R10 own id");
        access(0, 8'h21, 0, C_IDLE, 0, 32'h7777, "R10 own id kept");
        snoop(C_RDX, 8'h61, 2, 0, 0, "R10 other tag");
        access(1, 8'h21, 32'h7778, C_IDLE, 0, 0, "R10 still modified");
    endtask

    task automatic t_race;
        access(0, 8'h32, 0, C_RD, 32'h9, 32'h9, "R11 setup");
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = 8'h32; cpu_wdata = 32'hBEEF;
        @(negedge clk); #1;
        chk(bus_req, "R11 waiting", bus_req, 1);
        snp_cmd = C_UPG; snp_addr = 8'h32; snp_id = 2;
        @(negedge clk);
        snp_cmd = C_IDLE; bus_gnt = 1; #1;
        chk(bus_cmd == C_RDX, "R11 command", bus_cmd, C_RDX);
        @(negedge clk);
        bus_gnt = 0; bus_dvalid = 1; bus_rdata = 32'h77;
        @(negedge clk);
        bus_dvalid = 0; #1;
        chk(cpu_ready, "R11 completes", cpu_ready, 1);
        @(negedge clk);
        cpu_req = 0;
        access(0, 8'h32, 0, C_IDLE, 0, 32'hBEEF, "R11 word");
    endtask

    task automatic t_clash;
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 8'h21;
        snp_cmd = C_RD; snp_addr = 8'h61; snp_id = 2; #1;
        chk(!cpu_ready, "R12 held", cpu_ready, 0);
        @(negedge clk);
        snp_cmd = C_IDLE; #1;
        chk(cpu_ready && cpu_rdata == 32'h7778, "R12 after", cpu_rdata, 32'h7778);
        @(negedge clk);
        cpu_req = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_hits();
        t_upgrade();
        t_intervene();
        t_invalidate();
        t_write_miss();
        t_ignore();
        t_race();
        t_clash();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule